// File: doc/BRIEF.md
# Fast Ethernet Transmit Symbol Encoder

This block turns a nibble-wide transmit stream into the three-level line symbols of a 100 Mbps twisted-pair link. It runs entirely on the 125 MHz bit clock. An internal five-cycle slot counter stands in for the 25 MHz nibble clock: once per slot a 5-bit code group is chosen and loaded into a serializer. The group is an idle, a start, end or halt marker, or the 4B/5B image of the offered nibble. The serial bit is XORed with an 11-bit LFSR key and NRZI-coded. The NRZI level then drives a four-phase MLT-3 stepper whose state is the output symbol.

The nibble side is a valid/ready stream. `in_valid` plays the role of the transmit-enable and `in_err` the role of the transmit-error flag. The block asserts `in_ready` for one cycle per slot, and a nibble is taken on a clock edge where both `in_valid` and `in_ready` are high. A source must hold its nibble and flag until that edge. Within a frame it must offer a nibble at every slot, because the line cannot wait. The first slot at which `in_valid` is low closes the frame. During the one slot after that, which carries the second end marker, `in_ready` stays low, and this is the only back-pressure the block applies. The output side has no handshake: one symbol leaves on every clock.

Top module: `fe_tx_encoder`

## Requirements
- R1: While `rst_n` is low, `line_sym` is 0 and `in_ready` is 0. After release, counting the first cycle with `rst_n` high as cycle 0, `in_ready` is low in cycles 1 to 3.
- R2: `in_ready` is high in at most one cycle of every five. Its first high cycle after reset is cycle 4, and from then on it can only be high in every fifth cycle.
- R3: At any slot where no frame is active and `in_valid` is low, the idle group 11111 is loaded. `in_err` has no effect while `in_valid` is low.
- R4: The first two nibbles accepted in a frame are replaced by the start pair J = 11000 and then K = 10001, whatever their data and `in_err`.
- R5: Later accepted nibbles map nibble→group as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R6: A nibble accepted after the start pair with `in_err` high is sent as the halt group 00100 instead of its data group.
- R7: The first slot inside a frame where `in_valid` is low loads T = 01101, and the next slot loads R = 00111 with `in_ready` low. After R, a new frame may start with J at the very next slot.
- R8: Each serial bit is XORed with key = s[10] ^ s[8] of an 11-bit LFSR s. The LFSR shifts as s <= {s[9:0], key} on every clock and is held at the seed 11'h7FF during reset.
- R9: Group bit 0 is serialized first. Bit i of a group loaded at edge E is the serial bit in the cycle that follows edge E+i.
- R10: NRZI toggles on each scrambled 1 and holds on each 0. The MLT-3 output steps through 0, +1, 0, -1 on each NRZI change and holds otherwise. It is a 2-bit signed value (01 = +1, 11 = -1, 00 = 0) and is never 10.
- R11: The scrambled form of bit 0 of a group loaded at edge E first shows in `line_sym` after edge E+2. A change of `line_sym` after edge n therefore reports a scrambled 1 in the cycle that follows edge n-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Transmit-enable; nibble offered |
| in_nib | input | 4 | Transmit nibble |
| in_err | input | 1 | Transmit-error flag, qualified by `in_valid` |
| in_ready | output | 1 | Nibble slot open this cycle |
| line_sym | output | 2 | Signed three-level line symbol |

## Verification
The bench recovers code groups from the line by turning each symbol change back into a scrambled one and removing its own LFSR key. A wrong polynomial, bit order or latency therefore corrupts even the idle stream. Frames of one nibble and of many nibbles are driven, along with halt nibbles, an error flag raised outside a frame, and a second frame started as early as the end marker allows. A design that leaked an error flag into idle, forgot to replace a preamble nibble, accepted data during the R slot or inserted an idle between frames would show a misplaced group. A design that stepped the MLT-3 directly between +1 and -1 would break the phase-order check.

// File: rtl/fetx_pkg.sv
package fetx_pkg;
  localparam int NIB_W = 4;
  localparam int CG_W  = 5;

  typedef logic [CG_W-1:0] cgroup_t;

  localparam cgroup_t CG_IDLE = 5'b11111;
  localparam cgroup_t CG_J    = 5'b11000;
  localparam cgroup_t CG_K    = 5'b10001;
  localparam cgroup_t CG_T    = 5'b01101;
  localparam cgroup_t CG_R    = 5'b00111;
  localparam cgroup_t CG_H    = 5'b00100;

  typedef enum logic [1:0] {
    FR_IDLE,   // waiting for a frame
    FR_SSD2,   // J sent, K due
    FR_BODY,   // data groups
    FR_TAIL    // T sent, R due
  } fr_state_t;

  function automatic cgroup_t data_group(input logic [NIB_W-1:0] n);
    cgroup_t g;
    case (n)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/fetx_framer.sv
module fetx_framer
  import fetx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot,
  input  logic             in_valid,
  input  logic [NIB_W-1:0] in_nib,
  input  logic             in_err,
  output logic             in_ready,
  output cgroup_t          load_group
);
  fr_state_t state, state_nxt;
  cgroup_t   grp;

  assign in_ready   = slot && (state != FR_TAIL);
  assign load_group = grp;

  always_comb begin
    state_nxt = state;
    grp       = CG_IDLE;
    unique case (state)
      FR_IDLE: begin
        if (in_valid) begin
          grp       = CG_J;
          state_nxt = FR_SSD2;
        end
      end
      FR_SSD2: begin
        if (in_valid) begin
          grp       = CG_K;
          state_nxt = FR_BODY;
        end else begin
          grp       = CG_T;
          state_nxt = FR_TAIL;
        end
      end
      FR_BODY: begin
        if (in_valid) begin
          grp = in_err ? CG_H : data_group(in_nib);
        end else begin
          grp       = CG_T;
          state_nxt = FR_TAIL;
        end
      end
      FR_TAIL: begin
        grp       = CG_R;
        state_nxt = FR_IDLE;
      end
      default: begin
        grp       = CG_IDLE;
        state_nxt = FR_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= FR_IDLE;
    else if (slot) state <= state_nxt;
  end

  // R2: the nibble side only opens on a slot cycle
  assert_ready_on_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> slot);
  // R7: no nibble taken while R is due
  assert_tail_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FR_TAIL) |-> !in_ready);
  // R7: R lasts exactly one slot
  assert_tail_one_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && state == FR_TAIL) |=> (state == FR_IDLE));
  // R4: an accepted first nibble leads to the K slot
  assert_start_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && state == FR_IDLE && in_valid) |=> (state == FR_SSD2));
endmodule

// File: rtl/fetx_serializer.sv
module fetx_serializer
  import fetx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  cgroup_t load_group,
  output logic    slot,
  output logic    ser_bit
);
  localparam int CNT_W = $clog2(CG_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CG_W - 1);

  logic [CNT_W-1:0] cnt;
  cgroup_t          sh;

  assign slot    = (cnt == LAST);
  assign ser_bit = sh[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '1;
    end else begin
      cnt <= slot ? '0 : cnt + CNT_W'(1);
      sh  <= slot ? load_group : {1'b0, sh[CG_W-1:1]};
    end
  end

  // R9: slots never touch
  assert_slot_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    slot |=> !slot);
  // R9: least significant bit first
  assert_lsb_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    slot |=> (ser_bit == $past(load_group[0])));
endmodule

// File: rtl/fetx_scrambler.sv
module fetx_scrambler #(
  parameter int          LFSR_W = 11,
  parameter int          TAP    = 9,
  parameter logic [10:0] SEED   = 11'h7FF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  output logic bit_out
);
  logic [LFSR_W-1:0] lfsr;
  logic              key;

  assign key     = lfsr[LFSR_W-1] ^ lfsr[TAP-1];
  assign bit_out = bit_in ^ key;

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= LFSR_W'(SEED);
    else        lfsr <= {lfsr[LFSR_W-2:0], key};
  end

  // R8: the key sequence never collapses to all zeros
  assert_lfsr_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
endmodule

// File: rtl/fetx_line_coder.sv
module fetx_line_coder (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  output logic signed [1:0] sym
);
  logic       nrzi, nrzi_prev;
  logic [1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nrzi      <= 1'b0;
      nrzi_prev <= 1'b0;
      phase     <= 2'd0;
    end else begin
      nrzi      <= nrzi ^ bit_in;
      nrzi_prev <= nrzi;
      if (nrzi != nrzi_prev) phase <= phase + 2'd1;
    end
  end

  always_comb begin
    case (phase)
      2'd1:    sym = 2'sb01;
      2'd3:    sym = 2'sb11;
      default: sym = 2'sb00;
    endcase
  end

  // R10: only three levels
  assert_no_neg2_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sym != 2'sb10);
  // R10: a change always passes through zero
  assert_via_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sym != $past(sym)) |-> (sym == 2'sb00 || $past(sym) == 2'sb00));
  // R10: no NRZI change, no step
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (nrzi == nrzi_prev) |=> $stable(sym));
endmodule

// File: rtl/fe_tx_encoder.sv
module fe_tx_encoder
  import fetx_pkg::*;
#(
  parameter logic [10:0] LFSR_SEED = 11'h7FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_nib,
  input  logic              in_err,
  output logic              in_ready,
  output logic signed [1:0] line_sym
);
  cgroup_t load_group;
  logic    slot, ser_bit, scr_bit;

  fetx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .slot(slot), .in_valid(in_valid),
    .in_nib(in_nib), .in_err(in_err), .in_ready(in_ready),
    .load_group(load_group)
  );

  fetx_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .load_group(load_group),
    .slot(slot), .ser_bit(ser_bit)
  );

  fetx_scrambler #(.LFSR_W(11), .TAP(9), .SEED(LFSR_SEED)) u_scr (
    .clk(clk), .rst_n(rst_n), .bit_in(ser_bit), .bit_out(scr_bit)
  );

  fetx_line_coder u_line (
    .clk(clk), .rst_n(rst_n), .bit_in(scr_bit), .sym(line_sym)
  );

  // R11: a scrambled 1 is seen on the line two edges later
  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scr_bit && $past(rst_n)) |=> ##1 (line_sym != $past(line_sym)));
endmodule

// File: tb/fe_tx_encoder_tb.sv
`timescale 1ns/1ps
module fe_tx_encoder_tb;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_err = 0;
  logic [3:0] in_nib = 0;
  logic in_ready;
  logic signed [1:0] line_sym;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam logic [4:0] IDLE = 5'b11111, J = 5'b11000, K = 5'b10001,
                         T = 5'b01101, R = 5'b00111, H = 5'b00100;

  always #2.5 clk = ~clk;

  fe_tx_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_nib(in_nib),
    .in_err(in_err), .in_ready(in_ready), .line_sym(line_sym)
  );

  // ---- line decoder built from R8..R11 ----
  logic [10:0] m_lfsr;
  int cyc, last_nz, mlt_bad, ready_cnt, m_idx, b_idx;
  bit kd1, kd2, kb, rb;
  logic signed [1:0] sym_prev;
  logic [4:0] acc;
  logic [4:0] got[$];
  int got_start[$];

  always @(posedge clk)
    if (!rst_n) m_lfsr <= 11'h7FF;
    else        m_lfsr <= {m_lfsr[9:0], m_lfsr[10] ^ m_lfsr[8]};

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; sym_prev = 0; kd1 = 0; kd2 = 0; last_nz = 0; mlt_bad = 0;
    end else begin
      cyc++;
      kb = m_lfsr[10] ^ m_lfsr[8];
      m_idx = cyc - 2;
      if (m_idx >= 5) begin
        rb = (line_sym != sym_prev) ^ kd2;
        b_idx = m_idx % 5;
        acc[b_idx] = rb;
        if (b_idx == 4) begin got.push_back(acc); got_start.push_back(m_idx - 4); end
      end
      if (line_sym == 2'sb10) mlt_bad++;
      if (line_sym != sym_prev) begin
        if (line_sym != 0 && sym_prev != 0) mlt_bad++;
        if (line_sym != 0) begin
          if (last_nz != 0 && int'(line_sym) == last_nz) mlt_bad++;
          last_nz = int'(line_sym);
        end
      end
      if (in_ready) ready_cnt++;
      kd2 = kd1; kd1 = kb; sym_prev = line_sym;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [4:0] enc(input logic [3:0] n);
    logic [4:0] t[16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010,
                          5'b01011, 5'b01110, 5'b01111, 5'b10010, 5'b10011,
                          5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100,
                          5'b11101};
    return t[n];
  endfunction

  // wait for the edge that takes the offered nibble; returns its edge index
  task automatic wait_hs(output int h);
    bit r;
    forever begin
      @(negedge clk); #1; r = in_ready; h = cyc + 1;
      @(posedge clk); #1;
      if (r) break;
    end
  endtask

  task automatic drive_frame(input logic [4:0] f[$], output int hs_first,
                             output int hs_last);
    int h;
    foreach (f[k]) begin
      in_valid = 1; in_err = f[k][4]; in_nib = f[k][3:0];
      wait_hs(h);
      if (k == 0) hs_first = h;
      hs_last = h;
    end
    in_valid = 0; in_err = 0;
    wait_hs(h);  // the slot that sees valid low (T)
  endtask

  task automatic build(input logic [4:0] f[$], ref logic [4:0] e[$]);
    foreach (f[k]) begin
      if (k == 0)      e.push_back(J);
      else if (k == 1) e.push_back(K);
      else             e.push_back(f[k][4] ? H : enc(f[k][3:0]));
    end
    e.push_back(T); e.push_back(R);
  endtask

  task automatic check_stream(input logic [4:0] e[$], input string req,
                              output int start);
    int idx = 0;
    while (idx < got.size() && got[idx] == IDLE) idx++;
    start = (idx < got.size()) ? got_start[idx] : -1;
    foreach (e[j]) begin
      int a = (idx + j < got.size()) ? int'(got[idx + j]) : -1;
      chk(a == int'(e[j]), req, $sformatf("group %0d", j), a, e[j]);
    end
    begin
      int a = (idx + e.size() < got.size()) ? int'(got[idx + e.size()]) : -1;
      chk(a == int'(IDLE), "R3", "idle after frame", a, IDLE);
    end
  endtask

  task automatic flush();
    @(posedge clk); #1;
    got.delete(); got_start.delete();
  endtask

  task automatic settle(); repeat (25) @(posedge clk); #1; endtask

  // ---- scenarios ----
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(line_sym == 0, "R1", "symbol in reset", line_sym, 0);
    chk(in_ready == 0, "R1", "ready in reset", in_ready, 0);
    @(negedge clk); #1 rst_n = 1;
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk); #1;
      chk(in_ready == (cyc == 4), (cyc < 4) ? "R1" : "R2",
          $sformatf("ready at cycle %0d", cyc), in_ready, cyc == 4);
    end
    @(posedge clk); #1;
  endtask

  task automatic t_idle();
    int c0;
    flush();
    in_err = 1; in_nib = 4'hA;   // R3: error flag without valid
    c0 = ready_cnt;
    repeat (50) @(posedge clk); #1;
    chk(ready_cnt - c0 == 10, "R2", "ready cycles in 50", ready_cnt - c0, 10);
    in_err = 0;
    chk(got.size() >= 9, "R8", "idle groups decoded", got.size(), 9);
    foreach (got[i]) chk(got[i] == IDLE, "R3", "idle group", got[i], IDLE);
  endtask

  task automatic t_basic();
    logic [4:0] f[$], e[$];
    int hf, hl, st;
    flush();
    f = '{5'h05, 5'h05};
    for (int n = 0; n < 16; n++) f.push_back({1'b0, 4'(n)});
    build(f, e);
    drive_frame(f, hf, hl);
    settle();
    check_stream(e, "R5", st);
    chk(st == hf, "R11", "J start cycle vs handshake edge", st, hf);
  endtask

  task automatic t_error();
    logic [4:0] f[$], e[$];
    int hf, hl, st;
    flush();
    f = '{5'h15, 5'h05, 5'h03, 5'h1A, 5'h07};  // R4 err on preamble, R6 err on A
    build(f, e);
    chk(e[0] == J && e[3] == H, "R6", "expectation", e[3], H);
    drive_frame(f, hf, hl);
    settle();
    check_stream(e, "R6", st);
  endtask

  task automatic t_short();
    logic [4:0] f[$], e[$];
    int hf, hl, st;
    flush();
    f = '{5'h0C};
    e = '{J, T, R};
    drive_frame(f, hf, hl);
    settle();
    check_stream(e, "R7", st);
  endtask

  task automatic t_back2back();
    logic [4:0] fa[$], fb[$], e[$];
    int ha, hal, hb, hbl, st;
    flush();
    fa = '{5'h05, 5'h05, 5'h09, 5'h0E};
    fb = '{5'h05, 5'h05, 5'h01, 5'h00, 5'h0F};
    build(fa, e); build(fb, e);
    drive_frame(fa, ha, hal);
    drive_frame(fb, hb, hbl);
    chk(hb == hal + 15, "R7", "next J edge after last nibble", hb - hal, 15);
    settle();
    check_stream(e, "R7", st);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_basic();
    t_error();
    t_short();
    t_back2back();
    chk(mlt_bad == 0, "R10", "MLT-3 phase order violations", mlt_bad, 0);
    chk(last_nz != 0, "R10", "line ever left zero", last_nz, 1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule